// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sequences the external memory bus of a small 8-bit controller. It runs on the core clock, advances only on an oscillator-rate enable, and splits each machine cycle (twelve enabled ticks) into two bus slots of six ticks each. Every slot starts with an address latch strobe. During the strobe, port 0 carries the low address byte. Port 0 then turns into the data path for the rest of the slot. Port 2 carries the high address byte or the contents of the port 2 output register.

Two requesters feed the sequencer. The first is the code fetch path, which presents a program counter. The second is the data path, which presents an address, a pointer width, a direction and write data. A code fetch takes one slot. A data access takes a whole machine cycle and drops the address strobe in its second slot. The external-access select input and the program counter together decide whether a fetch uses the bus or is served on chip.

Both request inputs use valid/ready. A requester holds valid and its payload steady until it sees ready high at a clock edge. Ready is given only at bus slot boundaries, so back-pressure lasts at most one machine cycle. The returned code and read bytes come back as one-clock valid pulses and cannot be stalled.

Top module: `xmem_seq`

## Requirements
- R1: With no data access in progress, the address strobe `ale` rises once every 6 enabled ticks (one per slot) and stays high for the first 2 ticks of each slot.
- R2: Each data access suppresses exactly one strobe pulse: the strobe rise that starts the data cycle is followed by the next rise 12 enabled ticks later.
- R3: While `ale` is high, `p0_out` carries bits [7:0] of the address being accessed and `p0_oe` is 1. The byte returned for that access is the byte external memory gives at that address.
- R4: During an external code fetch, and during a data access with `dreq_wide`=1, `p2_out` carries address bits [15:8].
- R5: During a data access with `dreq_wide`=0, `p2_out` carries `p2_reg` and not address bits.
- R6: With `ext_sel`=0, every fetch address from 0000H to FFFFH goes to external memory, and `fetch_ext` reads 1.
- R7: With `ext_sel`=1, a fetch address at or below 0FFFH is accepted with no bus activity (`psen_n` stays high, no `code_valid`), and `fetch_ext` reads 0. An address above 0FFFH goes external.
- R8: `psen_n`, `rd_n` and `wr_n` are active low. Each goes low only while `ale` is low, at most one of them is low at a time, and each is high again before the next address phase.
- R9: `p0_oe` is 0 whenever `psen_n` or `rd_n` is low. The byte on `p0_in` is returned on `code_data`/`rd_data` with a `code_valid`/`rd_valid` pulse exactly one clock long.
- R10: While `wr_n` is low, `p0_oe` is 1 and `p0_out` carries the write data.
- R11: Synchronous active-high `rst` holds `ale` low, all strobes high and `p0_oe` at 0. The first enabled tick after release starts a machine cycle with `ale` high.
- R12: A pending data request is taken only at a machine cycle start and wins over a pending fetch there. While both are valid at that point, `dreq_ready` is 1 and `fetch_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator-rate tick enable |
| ext_sel | input | 1 | External-access select (0: all code external) |
| p2_reg | input | 8 | Port 2 output register contents |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request accepted this clock |
| fetch_addr | input | 16 | Program counter to fetch |
| fetch_ext | output | 1 | Decoded: current fetch address goes to the bus |
| code_valid | output | 1 | One-clock pulse with fetched code byte |
| code_data | output | 8 | Fetched code byte |
| dreq_valid | input | 1 | Data request valid |
| dreq_ready | output | 1 | Data request accepted this clock |
| dreq_addr | input | 16 | Data address |
| dreq_wide | input | 1 | 1: 16-bit pointer, 0: 8-bit register-indirect |
| dreq_write | input | 1 | 1: write, 0: read |
| dreq_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-clock pulse with read byte |
| rd_data | output | 8 | Read byte |
| ale | output | 1 | Address latch strobe |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 output enable |
| p0_in | input | 8 | Port 0 pad input |
| p2_out | output | 8 | Port 2 drive value |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 8-bit data, six ticks per slot and an on-chip code limit of 0FFFH. These values let it fetch just below and just above the on-chip limit with the select input both high and low. The bench also runs the tick enable at full clock rate and at half rate, so the strobe cadence is measured both in ticks and in clocks. Because a machine cycle is only twelve ticks, a reset released at a known point lines up both requesters on one cycle start, and the data-over-fetch priority can be shown there.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_CODE = 2'd1,
    SLOT_DRD  = 2'd2,
    SLOT_DWR  = 2'd3
  } slot_kind_e;

  function automatic logic is_data(slot_kind_e k);
    return (k == SLOT_DRD) || (k == SLOT_DWR);
  endfunction
endpackage

// File: rtl/xmem_phase.sv
module xmem_phase #(
  parameter int SLOT_TICKS = 6,
  localparam int CYC = 2 * SLOT_TICKS,
  localparam int PHW = $clog2(CYC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           osc_en,
  output logic [PHW-1:0] ph,
  output logic [PHW-1:0] slot_ph,
  output logic           upper_half,
  output logic           cyc_start,
  output logic           half_start
);
  localparam logic [PHW-1:0] PH_LAST = PHW'(CYC - 1);
  localparam logic [PHW-1:0] PH_SLOT = PHW'(SLOT_TICKS);

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_LAST;
    else if (osc_en) ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
  end

  always_comb begin
    upper_half = (ph >= PH_SLOT);
    slot_ph    = upper_half ? ph - PH_SLOT : ph;
    cyc_start  = osc_en && (ph == PH_LAST);
    half_start = osc_en && (ph == PH_SLOT - 1'b1);
  end
endmodule

// File: rtl/xmem_sched.sv
module xmem_sched import xmem_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] INT_TOP = 'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_start,
  input  logic          half_start,
  input  logic          ext_sel,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_ready,
  output logic          fetch_ext,
  input  logic          dreq_valid,
  input  logic [AW-1:0] dreq_addr,
  input  logic          dreq_wide,
  input  logic          dreq_write,
  input  logic [DW-1:0] dreq_wdata,
  output logic          dreq_ready,
  output slot_kind_e    kind,
  output logic [AW-1:0] lat_addr,
  output logic          lat_wide,
  output logic [DW-1:0] lat_wdata
);
  logic take_data, take_code;

  always_comb begin
    fetch_ext   = !ext_sel || (fetch_addr > INT_TOP);
    dreq_ready  = !rst && cyc_start;
    take_data   = dreq_ready && dreq_valid;
    fetch_ready = !rst && ((cyc_start && !dreq_valid) ||
                           (half_start && !is_data(kind)));
    take_code   = fetch_ready && fetch_valid && fetch_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind      <= SLOT_IDLE;
      lat_addr  <= '0;
      lat_wide  <= 1'b0;
      lat_wdata <= '0;
    end else if (take_data) begin
      kind      <= dreq_write ? SLOT_DWR : SLOT_DRD;
      lat_addr  <= dreq_addr;
      lat_wide  <= dreq_wide;
      lat_wdata <= dreq_wdata;
    end else if (take_code) begin
      kind      <= SLOT_CODE;
      lat_addr  <= fetch_addr;
      lat_wide  <= 1'b1;
    end else if (cyc_start || (half_start && !is_data(kind))) begin
      kind      <= SLOT_IDLE;
    end
  end
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins import xmem_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SLOT_TICKS = 6,
  localparam int CYC = 2 * SLOT_TICKS,
  localparam int PHW = $clog2(CYC),
  localparam int HW = AW - DW
) (
  input  slot_kind_e     kind,
  input  logic [PHW-1:0] ph,
  input  logic [PHW-1:0] slot_ph,
  input  logic           upper_half,
  input  logic [AW-1:0]  lat_addr,
  input  logic           lat_wide,
  input  logic [DW-1:0]  lat_wdata,
  input  logic [HW-1:0]  p2_reg,
  output logic           ale,
  output logic [DW-1:0]  p0_out,
  output logic           p0_oe,
  output logic [HW-1:0]  p2_out,
  output logic           psen_n,
  output logic           rd_n,
  output logic           wr_n
);
  localparam int ALE_TICKS = SLOT_TICKS / 3;
  localparam logic [PHW-1:0] ALE_END  = PHW'(ALE_TICKS);
  localparam logic [PHW-1:0] ADR_LAST = PHW'(ALE_TICKS);
  localparam logic [PHW-1:0] STB_ON   = PHW'(ALE_TICKS + 1);
  localparam logic [PHW-1:0] CODE_OFF = PHW'(SLOT_TICKS - 2);
  localparam logic [PHW-1:0] DATA_OFF = PHW'(CYC - 3);

  logic data_cyc, addr_phase, code_win, data_win;

  always_comb begin
    data_cyc   = is_data(kind);
    addr_phase = data_cyc ? (ph <= ADR_LAST) : (slot_ph <= ADR_LAST);
    code_win   = (kind == SLOT_CODE) && (slot_ph >= STB_ON) && (slot_ph <= CODE_OFF);
    data_win   = data_cyc && (ph >= STB_ON) && (ph <= DATA_OFF);

    ale    = (slot_ph < ALE_END) && !(data_cyc && upper_half);
    psen_n = !code_win;
    rd_n   = !(data_win && (kind == SLOT_DRD));
    wr_n   = !(data_win && (kind == SLOT_DWR));

    unique case (kind)
      SLOT_CODE: p0_oe = addr_phase;
      SLOT_DRD:  p0_oe = addr_phase;
      SLOT_DWR:  p0_oe = 1'b1;
      default:   p0_oe = 1'b0;
    endcase

    if (addr_phase && kind != SLOT_IDLE) p0_out = lat_addr[DW-1:0];
    else if (kind == SLOT_DWR)           p0_out = lat_wdata;
    else                                 p0_out = '1;

    if (kind == SLOT_CODE || (data_cyc && lat_wide)) p2_out = lat_addr[AW-1:DW];
    else                                             p2_out = p2_reg;
  end
endmodule

// File: rtl/xmem_capture.sv
module xmem_capture import xmem_pkg::*; #(
  parameter int DW = 8,
  parameter int SLOT_TICKS = 6,
  localparam int CYC = 2 * SLOT_TICKS,
  localparam int PHW = $clog2(CYC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           osc_en,
  input  slot_kind_e     kind,
  input  logic [PHW-1:0] ph,
  input  logic [PHW-1:0] slot_ph,
  input  logic [DW-1:0]  p0_in,
  output logic           code_valid,
  output logic [DW-1:0]  code_data,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data
);
  localparam logic [PHW-1:0] CODE_SMP = PHW'(SLOT_TICKS - 2);
  localparam logic [PHW-1:0] DATA_SMP = PHW'(CYC - 3);

  logic code_smp, data_smp;

  always_comb begin
    code_smp = osc_en && (kind == SLOT_CODE) && (slot_ph == CODE_SMP);
    data_smp = osc_en && (kind == SLOT_DRD) && (ph == DATA_SMP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_valid <= 1'b0;
      rd_valid   <= 1'b0;
      code_data  <= '0;
      rd_data    <= '0;
    end else begin
      code_valid <= code_smp;
      rd_valid   <= data_smp;
      if (code_smp) code_data <= p0_in;
      if (data_smp) rd_data   <= p0_in;
    end
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq import xmem_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SLOT_TICKS = 6,
  parameter logic [AW-1:0] INT_TOP = 'h0FFF,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic          ext_sel,
  input  logic [HW-1:0] p2_reg,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_ext,
  output logic          code_valid,
  output logic [DW-1:0] code_data,
  input  logic          dreq_valid,
  output logic          dreq_ready,
  input  logic [AW-1:0] dreq_addr,
  input  logic          dreq_wide,
  input  logic          dreq_write,
  input  logic [DW-1:0] dreq_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ale,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  input  logic [DW-1:0] p0_in,
  output logic [HW-1:0] p2_out,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int PHW = $clog2(2 * SLOT_TICKS);

  logic [PHW-1:0] ph, slot_ph;
  logic           upper_half, cyc_start, half_start;
  slot_kind_e     kind;
  logic [AW-1:0]  lat_addr;
  logic           lat_wide;
  logic [DW-1:0]  lat_wdata;

  xmem_phase #(.SLOT_TICKS(SLOT_TICKS)) u_phase (
    .clk(clk), .rst(rst), .osc_en(osc_en), .ph(ph), .slot_ph(slot_ph),
    .upper_half(upper_half), .cyc_start(cyc_start), .half_start(half_start));

  xmem_sched #(.AW(AW), .DW(DW), .INT_TOP(INT_TOP)) u_sched (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .half_start(half_start),
    .ext_sel(ext_sel), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_ext(fetch_ext), .dreq_valid(dreq_valid),
    .dreq_addr(dreq_addr), .dreq_wide(dreq_wide), .dreq_write(dreq_write),
    .dreq_wdata(dreq_wdata), .dreq_ready(dreq_ready), .kind(kind),
    .lat_addr(lat_addr), .lat_wide(lat_wide), .lat_wdata(lat_wdata));

  xmem_pins #(.AW(AW), .DW(DW), .SLOT_TICKS(SLOT_TICKS)) u_pins (
    .kind(kind), .ph(ph), .slot_ph(slot_ph), .upper_half(upper_half),
    .lat_addr(lat_addr), .lat_wide(lat_wide), .lat_wdata(lat_wdata),
    .p2_reg(p2_reg), .ale(ale), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n));

  xmem_capture #(.DW(DW), .SLOT_TICKS(SLOT_TICKS)) u_cap (
    .clk(clk), .rst(rst), .osc_en(osc_en), .kind(kind), .ph(ph),
    .slot_ph(slot_ph), .p0_in(p0_in), .code_valid(code_valid),
    .code_data(code_data), .rd_valid(rd_valid), .rd_data(rd_data));
endmodule

// File: rtl/xmem_seq_chk.sv
module xmem_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SLOT_TICKS = 6,
  localparam int HW = AW - DW
) (
  input logic          clk,
  input logic          rst,
  input logic          osc_en,
  input logic          ale,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          p0_oe,
  input logic [HW-1:0] p2_out,
  input logic [HW-1:0] p2_reg,
  input logic [AW-1:0] lat_addr,
  input logic          lat_wide,
  input logic          code_valid,
  input logic          rd_valid
);
  localparam int CYC = 2 * SLOT_TICKS;

  logic       ale_q, seen_rise, saw_data, ale_rise;
  logic [7:0] ticks;

  assign ale_rise = ale && !ale_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q     <= 1'b0;
      seen_rise <= 1'b0;
      saw_data  <= 1'b0;
      ticks     <= '0;
    end else begin
      ale_q <= ale;
      if (ale_rise) begin
        seen_rise <= 1'b1;
        saw_data  <= 1'b0;
        ticks     <= {7'd0, osc_en};
      end else begin
        if (!rd_n || !wr_n) saw_data <= 1'b1;
        if (osc_en && ticks != 8'hFF) ticks <= ticks + 8'd1;
      end
    end
  end

  AST_ALE_CADENCE: assert property (@(posedge clk) disable iff (rst)
    (ale_rise && seen_rise && !saw_data) |-> (ticks == 8'(SLOT_TICKS))); // R1
  AST_ALE_DROP: assert property (@(posedge clk) disable iff (rst)
    (ale_rise && seen_rise && saw_data) |-> (ticks == 8'(CYC))); // R2
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R8
  AST_P0_TURNED: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !p0_oe); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    (code_valid || rd_valid) |=> !(code_valid && $past(code_valid)) && !(rd_valid && $past(rd_valid))); // R9
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> p0_oe); // R10
  AST_P2_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || ((!rd_n || !wr_n) && lat_wide)) |-> (p2_out == lat_addr[AW-1:DW])); // R4
  AST_P2_REG: assert property (@(posedge clk) disable iff (rst)
    ((!rd_n || !wr_n) && !lat_wide) |-> (p2_out == p2_reg)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ale && psen_n && rd_n && wr_n && !p0_oe)); // R11
endmodule

bind xmem_seq xmem_seq_chk #(.AW(AW), .DW(DW), .SLOT_TICKS(SLOT_TICKS)) u_chk (
  .clk(clk), .rst(rst), .osc_en(osc_en), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .p0_oe(p0_oe), .p2_out(p2_out), .p2_reg(p2_reg),
  .lat_addr(lat_addr), .lat_wide(lat_wide), .code_valid(code_valid),
  .rd_valid(rd_valid));

// File: tb/xmem_seq_test.sv
module xmem_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1, osc_en = 1'b1, ext_sel = 1'b0;
  logic [7:0] p2_reg = 8'h6E;
  logic fetch_valid = 1'b0, dreq_valid = 1'b0;
  logic [15:0] fetch_addr = '0, dreq_addr = '0;
  logic dreq_wide = 1'b0, dreq_write = 1'b0;
  logic [7:0] dreq_wdata = '0;
  logic fetch_ready, fetch_ext, code_valid, dreq_ready, rd_valid;
  logic [7:0] code_data, rd_data, p0_out, p2_out, p0_in;
  logic ale, p0_oe, psen_n, rd_n, wr_n;

  int total = 0, bad = 0, div = 1;

  always #4 clk = ~clk;

  xmem_seq uut (
    .clk(clk), .rst(rst), .osc_en(osc_en), .ext_sel(ext_sel), .p2_reg(p2_reg),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_ext(fetch_ext), .code_valid(code_valid), .code_data(code_data),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr),
    .dreq_wide(dreq_wide), .dreq_write(dreq_write), .dreq_wdata(dreq_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ale(ale), .p0_out(p0_out),
    .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n));

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // external memory model: latches the address while the strobe is high
  logic [15:0] ext_lat = '0;
  always @(negedge clk) if (ale && p0_oe) ext_lat <= {p2_out, p0_out};
  assign p0_in = (!psen_n || !rd_n) ? mem_val(ext_lat) : 8'h00;

  always @(negedge clk) osc_en <= (div == 1) ? 1'b1 : ~osc_en;

  // bus monitor
  int clk_n = 0, last_rise = -1, min_int = 1000, max_int = 0;
  int n_psen = 0, n_code = 0, n_rd = 0, stb_bad = 0, oe_bad = 0, pulse_bad = 0;
  logic ale_p = 0, psen_p = 1, code_p = 0, rd_p = 0;
  logic [7:0] code_last, rd_last, p2_seen, p0_wr_seen;
  always @(negedge clk) begin
    clk_n++;
    if (ale && !ale_p) begin
      if (last_rise >= 0) begin
        if (clk_n - last_rise < min_int) min_int = clk_n - last_rise;
        if (clk_n - last_rise > max_int) max_int = clk_n - last_rise;
      end
      last_rise = clk_n;
    end
    if (!psen_n && psen_p) n_psen++;
    if (code_valid) begin n_code++; code_last = code_data; end
    if (rd_valid) begin n_rd++; rd_last = rd_data; end
    if (!psen_n || !rd_n || !wr_n) p2_seen = p2_out;
    if (!wr_n) p0_wr_seen = p0_out;
    if (!rst && (ale && (!psen_n || !rd_n || !wr_n))) stb_bad++;
    if (!rst && ((!psen_n || !rd_n) && p0_oe)) oe_bad++;
    if (!rst && ((!wr_n) && !p0_oe)) oe_bad++;
    if ((code_valid && code_p) || (rd_valid && rd_p)) pulse_bad++;
    ale_p = ale; psen_p = psen_n; code_p = code_valid; rd_p = rd_valid;
  end

  task automatic clear_stats();
    last_rise = -1; min_int = 1000; max_int = 0;
    n_psen = 0; n_code = 0; n_rd = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n && !p0_oe, "R11 reset quiet",
        {ale, psen_n, rd_n, wr_n, p0_oe}, 5'b01110);
    rst = 1'b0;
    @(negedge clk);
    chk(ale == 1'b1, "R11 cycle start after release", ale, 1);
  endtask

  task automatic t_cadence(input int d);
    div = d;
    repeat (4) @(negedge clk);
    @(posedge clk); clear_stats();
    repeat (60 * d) @(negedge clk);
    chk(min_int == 6 * d && max_int == 6 * d, "R1 strobe period", max_int, 6 * d);
    div = 1;
  endtask

  task automatic do_fetch(input logic sel, input logic [15:0] a, input bit exp_ext);
    ext_sel = sel;
    @(posedge clk); clear_stats();
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    #1;
    chk(fetch_ext == exp_ext, exp_ext ? "R6 fetch_ext high" : "R7 fetch_ext low", fetch_ext, exp_ext);
    for (int i = 0; i < 40 && !fetch_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk); fetch_valid = 1'b0;
    repeat (30) @(negedge clk);
    if (exp_ext) begin
      chk(n_psen == 1 && n_code == 1, "R6 one external fetch", n_psen, 1);
      chk(code_last == mem_val(a), "R3 code byte", code_last, mem_val(a));
      chk(p2_seen == a[15:8], "R4 high byte on port 2", p2_seen, a[15:8]);
    end else begin
      chk(n_psen == 0 && n_code == 0, "R7 internal fetch, bus quiet", n_psen, 0);
    end
  endtask

  task automatic do_data(input logic [15:0] a, input bit wide, input bit wr, input logic [7:0] wd);
    logic [15:0] ea;
    ea = wide ? a : {p2_reg, a[7:0]};
    @(posedge clk); clear_stats();
    @(negedge clk);
    dreq_valid = 1'b1; dreq_addr = a; dreq_wide = wide; dreq_write = wr; dreq_wdata = wd;
    for (int i = 0; i < 40 && !dreq_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk); dreq_valid = 1'b0;
    repeat (36) @(negedge clk);
    chk(max_int == 12 && min_int == 6, "R2 one strobe dropped", max_int, 12);
    chk(p2_seen == ea[15:8], wide ? "R4 port 2 address" : "R5 port 2 register",
        p2_seen, ea[15:8]);
    if (wr) begin
      chk(p0_wr_seen == wd, "R10 write data on port 0", p0_wr_seen, wd);
    end else begin
      chk(n_rd == 1 && rd_last == mem_val(ea), "R3 read byte", rd_last, mem_val(ea));
    end
  endtask

  task automatic t_priority();
    @(negedge clk); rst = 1'b1; ext_sel = 1'b0;
    fetch_valid = 1'b1; fetch_addr = 16'h3C51;
    dreq_valid = 1'b1; dreq_addr = 16'h8E27; dreq_wide = 1'b1; dreq_write = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; clear_stats();
    #1;
    chk(dreq_ready && !fetch_ready, "R12 data first", {dreq_ready, fetch_ready}, 2'b10);
    @(posedge clk);
    @(negedge clk); dreq_valid = 1'b0;
    for (int i = 0; i < 40 && !fetch_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk); fetch_valid = 1'b0;
    chk(n_rd == 1 && n_code == 0, "R12 read returns before fetch", n_rd, 1);
    repeat (20) @(negedge clk);
    chk(n_code == 1 && code_last == mem_val(16'h3C51), "R12 fetch served after", code_last,
        mem_val(16'h3C51));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    dreq_valid = 1'b1; dreq_addr = 16'h2468; dreq_wide = 1'b1; dreq_write = 1'b1;
    dreq_wdata = 8'hA5;
    for (int i = 0; i < 40 && !dreq_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk); dreq_valid = 1'b0;
    for (int i = 0; i < 20 && wr_n; i++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(wr_n && !p0_oe && !ale, "R11 reset during write", {wr_n, p0_oe, ale}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(ale == 1'b1 && wr_n, "R11 restart after mid-cycle reset", ale, 1);
  endtask

  task automatic run_all();
    t_reset();
    t_cadence(1);
    t_cadence(2);
    do_fetch(1'b0, 16'h0234, 1'b1);
    do_fetch(1'b0, 16'hFFFF, 1'b1);
    do_fetch(1'b1, 16'h0FFF, 1'b0);
    do_fetch(1'b1, 16'h1000, 1'b1);
    do_data(16'hC3A5, 1'b1, 1'b0, 8'h00);
    do_data(16'h7F19, 1'b0, 1'b0, 8'h00);
    do_data(16'h4B2C, 1'b1, 1'b1, 8'h9D);
    do_data(16'h51E0, 1'b0, 1'b1, 8'h3B);
    t_priority();
    chk(stb_bad == 0, "R8 no strobe while ale high", stb_bad, 0);
    chk(oe_bad == 0, "R9 port 0 turned around", oe_bad, 0);
    chk(pulse_bad == 0, "R9 single-clock valid", pulse_bad, 0);
    t_reset_mid();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule